// File: doc/BRIEF.md
# Segmented Mantissa Product Array

This block multiplies two unsigned 52-bit mantissa fields and returns their exact 104-bit product. Each operand is cut into four 13-bit segments. A four-by-four grid of multiply cells forms the sixteen segment products. Each segment product has a weight of 13 times the sum of its two segment indices.

The weighted products are not summed in one wide adder. The block cuts each one at bit 52 into a lower half and an upper half. Products whose weight lies entirely below bit 52 give only a lower half, and those entirely above give only an upper half. Products of weight 39 straddle the cut and give one half to each side. This yields ten operands for each of two narrow adder trees.

Each tree reduces its ten operands in four registered stages. The lower tree's sum may spill past bit 52. Those extra bits are added into the upper tree's sum at the output, so the result is exact. A caller drives both operands with a one-cycle start pulse and collects the product when the valid flag rises.

Top module: `seg_mant_mul`

## Requirements
- R1: While reset is asserted and after it is released with no start pulse, `prod_valid` is 0 and `prod` is 0.
- R2: Operand bits [13k+12:13k] form segment k (k = 0..3). Cell (i,j) forms the product of A segment i and B segment j. Cells whose i+j is even store the A segment and take the B segment from cell (i^1,j). Cells whose i+j is odd store the B segment and take the A segment from cell (i,j^1).
- R3: The reported product equals the full 104-bit unsigned product op_a × op_b for any pair of operands, including all-ones operands.
- R4: If `start` is sampled high at a rising edge, `prod_valid` is high after the fifth rising edge counted from that one (one load cycle plus four tree stages). For a single start it is low both before and after that point.
- R5: Operands are captured only at the edge that samples `start` high. Changing `op_a`/`op_b` while `start` is low does not alter the product in flight.
- R6: Starts on consecutive cycles produce their products on consecutive cycles, in the same order.
- R7: A zero on either operand yields a zero product.
- R8: Carry bits of the lower-half sum above bit 51 are added into the upper half. An example is all-ones × all-ones = 2^104 − 2^53 + 1.
- R9: The upper tree's own sum never exceeds 52 bits.
- R10: When no further start arrives, `prod` keeps showing the last product after `prod_valid` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Sample the operands and begin a product |
| op_a | input | 52 | First unsigned mantissa |
| op_b | input | 52 | Second unsigned mantissa |
| prod | output | 104 | Exact unsigned product |
| prod_valid | output | 1 | High for one cycle when `prod` holds a new result |

## Verification
The following properties are checked on every cycle:
- The valid flag appears only five edges after a start.
- A zero operand gives a zero result.
- The upper-tree sum stays within 52 bits.
- An all-zero operand set leaving the tree gives a zero sum four stages later.

Only the bench's scenarios can show the other behaviours:
- The exact value of the product, including the carry across the cut at bit 52.
- That operands are captured only on start.
- Ordering of back-to-back products.
- That the result is held while idle.

The bench checks these against products it computes at full width.

// File: rtl/seg_mul_pkg.sv
package seg_mul_pkg;
    localparam int NSEG     = 4;
    localparam int CUT_K    = NSEG - 1;
    localparam int TREE_OPS = 10;
    localparam int TREE_STG = 4;
    localparam int LATENCY  = TREE_STG + 1;

    function automatic int lo_slot(input int i, input int j);
        int n;
        n = 0;
        for (int a = 0; a < NSEG; a++)
            for (int b = 0; b < NSEG; b++)
                if ((a * NSEG + b) < (i * NSEG + j) && (a + b) <= CUT_K)
                    n++;
        return n;
    endfunction

    function automatic int hi_slot(input int i, input int j);
        int n;
        n = 0;
        for (int a = 0; a < NSEG; a++)
            for (int b = 0; b < NSEG; b++)
                if ((a * NSEG + b) < (i * NSEG + j) && (a + b) >= CUT_K)
                    n++;
        return n;
    endfunction
endpackage

// File: rtl/seg_cell.sv
module seg_cell #(
    parameter int SEG_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [SEG_W-1:0]   seg_in,
    input  logic [SEG_W-1:0]   mcand_in,
    output logic [SEG_W-1:0]   held_out,
    output logic [2*SEG_W-1:0] prod_out
);
    logic [SEG_W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= '0;
        else if (load)
            held_q <= seg_in;
    end

    assign held_out = held_q;
    assign prod_out = (2*SEG_W)'(held_q) * (2*SEG_W)'(mcand_in);
endmodule

// File: rtl/half_tree.sv
module half_tree
    import seg_mul_pkg::*;
#(
    parameter int W_IN  = 52,
    parameter int W_OUT = W_IN + 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [TREE_OPS-1:0][W_IN-1:0]     ops,
    output logic [W_OUT-1:0]                  sum_out
);
    localparam int N1 = TREE_OPS / 2;

    logic [N1-1:0][W_OUT-1:0] s1_q;
    logic [2:0][W_OUT-1:0]    s2_q;
    logic [1:0][W_OUT-1:0]    s3_q;
    logic [W_OUT-1:0]         s4_q;

    for (genvar k = 0; k < N1; k++) begin : g_stage1
        always_ff @(posedge clk) begin
            if (!rst_n)
                s1_q[k] <= '0;
            else
                s1_q[k] <= W_OUT'(ops[2*k]) + W_OUT'(ops[2*k+1]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_q <= '0;
            s3_q <= '0;
            s4_q <= '0;
        end else begin
            s2_q[0] <= s1_q[0] + s1_q[1];
            s2_q[1] <= s1_q[2] + s1_q[3];
            s2_q[2] <= s1_q[4];
            s3_q[0] <= s2_q[0] + s2_q[1];
            s3_q[1] <= s2_q[2];
            s4_q    <= s3_q[0] + s3_q[1];
        end
    end

    assign sum_out = s4_q;

    p_tree_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ops == '0, 4) |-> (sum_out == '0))
        else $error("tree produced nonzero sum from zero operands");
endmodule

// File: rtl/seg_mant_mul.sv
module seg_mant_mul
    import seg_mul_pkg::*;
#(
    parameter int SEG_W = 13
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [NSEG*SEG_W-1:0]       op_a,
    input  logic [NSEG*SEG_W-1:0]       op_b,
    output logic [2*NSEG*SEG_W-1:0]     prod,
    output logic                        prod_valid
);
    localparam int HALF  = NSEG * SEG_W;
    localparam int P_W   = 2 * HALF;
    localparam int ACC_W = HALF + 4;

    logic [NSEG-1:0][NSEG-1:0][SEG_W-1:0]   held;
    logic [NSEG-1:0][NSEG-1:0][2*SEG_W-1:0] cprod;
    logic [TREE_OPS-1:0][HALF-1:0]          lo_ops;
    logic [TREE_OPS-1:0][HALF-1:0]          hi_ops;
    logic [ACC_W-1:0]                       lo_sum;
    logic [ACC_W-1:0]                       hi_sum;
    logic [LATENCY-1:0]                     vpipe;

    // R2: segment grid, each cell stores one segment, neighbour supplies the other
    for (genvar i = 0; i < NSEG; i++) begin : g_row
        for (genvar j = 0; j < NSEG; j++) begin : g_col
            localparam int K = i + j;
            logic [SEG_W-1:0] seg_src;
            logic [SEG_W-1:0] mcand;
            if ((K % 2) == 0) begin : g_keep_a
                assign seg_src = op_a[i*SEG_W +: SEG_W];
                assign mcand   = held[i^1][j];
            end else begin : g_keep_b
                assign seg_src = op_b[j*SEG_W +: SEG_W];
                assign mcand   = held[i][j^1];
            end

            seg_cell #(.SEG_W(SEG_W)) u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (start),
                .seg_in   (seg_src),
                .mcand_in (mcand),
                .held_out (held[i][j]),
                .prod_out (cprod[i][j])
            );

            if (K < CUT_K) begin : g_low_only
                assign lo_ops[lo_slot(i, j)] = HALF'(cprod[i][j]) << (SEG_W * K);
            end else if (K == CUT_K) begin : g_straddle
                assign lo_ops[lo_slot(i, j)] = HALF'(cprod[i][j]) << (SEG_W * K);
                assign hi_ops[hi_slot(i, j)] = HALF'(cprod[i][j] >> (HALF - SEG_W * K));
            end else begin : g_high_only
                assign hi_ops[hi_slot(i, j)] = HALF'(cprod[i][j]) << (SEG_W * (K - NSEG));
            end
        end
    end

    half_tree #(.W_IN(HALF), .W_OUT(ACC_W)) u_lo_tree (
        .clk     (clk),
        .rst_n   (rst_n),
        .ops     (lo_ops),
        .sum_out (lo_sum)
    );

    half_tree #(.W_IN(HALF), .W_OUT(ACC_W)) u_hi_tree (
        .clk     (clk),
        .rst_n   (rst_n),
        .ops     (hi_ops),
        .sum_out (hi_sum)
    );

    // R4: valid follows start through load stage and four tree stages
    always_ff @(posedge clk) begin
        if (!rst_n)
            vpipe <= '0;
        else
            vpipe <= {vpipe[LATENCY-2:0], start};
    end

    // R8: low-half overflow joins the upper half
    always_comb begin
        prod       = {hi_sum[HALF-1:0], {HALF{1'b0}}} + P_W'(lo_sum);
        prod_valid = vpipe[LATENCY-1];
    end

    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prod_valid |-> $past(start, 5))
        else $error("valid without a start five edges earlier");

    p_zero_operand_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_valid && $past(start && (op_a == '0 || op_b == '0), 5)) |-> (prod == '0))
        else $error("zero operand gave nonzero product");

    p_high_fits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prod_valid |-> (hi_sum[ACC_W-1:HALF] == '0))
        else $error("upper tree sum exceeds 52 bits");
endmodule

// File: tb/test_seg_mant_mul.sv
module test_seg_mant_mul;
    localparam int CLK_PERIOD = 10;
    localparam int OW = 52;
    localparam int PW = 104;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [OW-1:0] op_a = '0;
    logic [OW-1:0] op_b = '0;
    logic [PW-1:0] prod;
    logic          prod_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_mant_mul i_seg_mant_mul (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .op_a       (op_a),
        .op_b       (op_b),
        .prod       (prod),
        .prod_valid (prod_valid)
    );

    function automatic logic [PW-1:0] ref_mul(input logic [OW-1:0] a, input logic [OW-1:0] b);
        logic [PW-1:0] x;
        logic [PW-1:0] y;
        x = {{(PW-OW){1'b0}}, a};
        y = {{(PW-OW){1'b0}}, b};
        return x * y;
    endfunction

    function automatic logic [OW-1:0] rnd52();
        return {$urandom(), $urandom()} & {OW{1'b1}};
    endfunction

    task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // single product: latency window, value, one-cycle valid
    task automatic t_single(input string req, input logic [OW-1:0] a, input logic [OW-1:0] b);
        @(negedge clk);
        op_a = a; op_b = b; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R4 valid early", PW'(prod_valid), PW'(0));
        @(posedge clk);
        @(negedge clk);
        check("R4 valid on time", PW'(prod_valid), PW'(1));
        check(req, prod, ref_mul(a, b));
        @(posedge clk);
        @(negedge clk);
        check("R4 valid one cycle", PW'(prod_valid), PW'(0));
    endtask

    task automatic t_reset();
        repeat (6) @(posedge clk);
        @(negedge clk);
        check("R1 valid in reset", PW'(prod_valid), PW'(0));
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 valid after reset", PW'(prod_valid), PW'(0));
        check("R1 product after reset", prod, PW'(0));
    endtask

    task automatic t_capture_once();
        logic [OW-1:0] a;
        logic [OW-1:0] b;
        a = rnd52(); b = rnd52();
        @(negedge clk);
        op_a = a; op_b = b; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        op_a = ~a; op_b = rnd52();
        repeat (2) @(posedge clk);
        @(negedge clk);
        op_a = rnd52(); op_b = '1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R5 capture only on start", prod, ref_mul(a, b));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 result held while idle", prod, ref_mul(a, b));
        check("R10 valid low while idle", PW'(prod_valid), PW'(0));
    endtask

    task automatic t_back_to_back();
        logic [OW-1:0] a [3];
        logic [OW-1:0] b [3];
        for (int k = 0; k < 3; k++) begin
            a[k] = rnd52(); b[k] = rnd52();
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            op_a = a[k]; op_b = b[k]; start = 1'b1;
            @(posedge clk);
        end
        @(negedge clk);
        start = 1'b0;
        @(posedge clk);
        @(posedge clk);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R6 streamed valid", PW'(prod_valid), PW'(1));
            check("R6 streamed product", prod, ref_mul(a[k], b[k]));
            @(posedge clk);
        end
        @(negedge clk);
        check("R6 stream ends", PW'(prod_valid), PW'(0));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        t_reset();
        t_single("R3 small values", 52'd3, 52'd5);
        t_single("R8 all ones carry", '1, '1);
        t_single("R7 zero on A", '0, rnd52());
        t_single("R7 zero on B", rnd52(), '0);
        t_single("R2 single segment A0 x B3", 52'h0000000001FFF, 52'hFFF8000000000);
        t_single("R2 single segment A3 x B0", 52'hFFF8000000000, 52'h0000000001FFF);
        t_single("R3 straddling segment", 52'h0000FFF800000, 52'h00000000FFFFF);
        t_single("R3 unit operand", 52'd1, '1);
        for (int k = 0; k < 8; k++)
            t_single("R3 random", rnd52(), rnd52());
        t_capture_once();
        t_back_to_back();
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule